// File: doc/BRIEF.md
# Small-Constant Divider by Scaled Reciprocal

This block computes the exact floor quotient and remainder of an unsigned numerator divided by one of four fixed small divisors, without a sequential divider. A 2-bit select picks the divisor. A small constant table gives the divisor and its scaled reciprocal, floor(2^SHIFT / divisor). The first pipeline stage multiplies the numerator by that reciprocal and shifts the product right by SHIFT bits. This gives an estimate that truncation can leave one below the true quotient.

The second stage tests whether the next multiple of the divisor still fits inside the numerator. If it does, the stage adds one to the estimate. It then forms the remainder from the corrected quotient. The block accepts one operation per clock. Each result appears with its valid flag two clocks after the operands. It suits datapaths that divide by a handful of known constants at full throughput.

Top module: `scdiv_top`

## Requirements
- R1: The select maps code 2'b00 to divisor 1, 2'b01 to 3, 2'b10 to 6 and 2'b11 to 10. For every accepted operand, out_quo equals floor(in_num / divisor).
- R2: For every result, out_rem equals in_num minus divisor times out_quo, and out_rem is strictly less than the divisor.
- R3: out_valid is high in the cycle two clock edges after in_valid was sampled high. That result belongs to the operands sampled with it.
- R4: While rst is high at a clock edge, out_valid, out_quo and out_rem become 0 after that edge.
- R5: Operands presented on consecutive cycles each produce their own correct result on consecutive cycles.
- R6: Numerator 0 gives quotient 0 and remainder 0 for every divisor. Numerator 32767 (the largest 15-bit value) gives an exact result for every divisor.
- R7: A cycle with in_valid low yields out_valid low two edges later. While out_valid is low, out_quo and out_rem keep their last values.
- R8: When the truncated estimate is one short, the result is still exact. For example, 3/3, 6/6 and 10/10 each give 1 remainder 0, and 32767/3 gives 10922 remainder 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on in_num and in_sel are valid |
| in_num | input | NUM_W (15) | Unsigned numerator |
| in_sel | input | SEL_W (2) | Divisor select code |
| out_valid | output | 1 | Quotient and remainder are valid |
| out_quo | output | NUM_W (15) | Floor quotient |
| out_rem | output | DIV_W (4) | Remainder |

## Verification
The bench builds the block with its default parameters: a 15-bit numerator, a 2-bit select, a 4-bit divisor width and a 17-bit shift. With these values, every numerator from 0 to 32767 against all four divisors fits in about 131 thousand streamed cycles. The whole input space is therefore checked exhaustively, including each case where the estimate falls short and needs correcting. Directed sequences add reset in the middle of a stream, bubbles interleaved with valid operands, and the numerator extremes.

// File: rtl/scdiv_pkg.sv
package scdiv_pkg;

  // Divisor value behind each select code.
  function automatic int divisor_of(input int code);
    case (code)
      0:       return 1;
      1:       return 3;
      2:       return 6;
      3:       return 10;
      default: return 1;
    endcase
  endfunction

  // Scaled reciprocal floor(2^sh / b).
  function automatic longint recip_of(input int b, input int sh);
    return (longint'(1) << sh) / longint'(b);
  endfunction

endpackage

// File: rtl/scdiv_recip_rom.sv
module scdiv_recip_rom #(
  parameter int SEL_W = 2,
  parameter int DIV_W = 4,
  parameter int SHIFT = 17,
  parameter int K_W   = SHIFT + 1
) (
  input  logic [SEL_W-1:0] sel,
  output logic [DIV_W-1:0] divisor,
  output logic [K_W-1:0]   recip
);
  localparam int N_ENT = 1 << SEL_W;

  logic [DIV_W-1:0] div_tab [N_ENT];
  logic [K_W-1:0]   k_tab   [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign div_tab[i] = DIV_W'(scdiv_pkg::divisor_of(i));
    assign k_tab[i]   = K_W'(scdiv_pkg::recip_of(scdiv_pkg::divisor_of(i), SHIFT));
  end

  assign divisor = div_tab[sel];
  assign recip   = k_tab[sel];
endmodule

// File: rtl/scdiv_est_stage.sv
module scdiv_est_stage #(
  parameter int NUM_W  = 15,
  parameter int DIV_W  = 4,
  parameter int SHIFT  = 17,
  parameter int K_W    = SHIFT + 1,
  parameter int PROD_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_in,
  input  logic [NUM_W-1:0] num_in,
  input  logic [DIV_W-1:0] div_in,
  input  logic [K_W-1:0]   k_in,
  output logic             v_q,
  output logic [NUM_W-1:0] num_q,
  output logic [DIV_W-1:0] div_q,
  output logic [NUM_W-1:0] est_q
);
  logic [PROD_W-1:0] prod;
  logic [NUM_W-1:0]  est;

  always_comb begin
    prod = PROD_W'(num_in) * PROD_W'(k_in);
    est  = NUM_W'(prod >> SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      num_q <= '0;
      div_q <= '0;
      est_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        num_q <= num_in;
        div_q <= div_in;
        est_q <= est;
      end
    end
  end
endmodule

// File: rtl/scdiv_fix_stage.sv
module scdiv_fix_stage #(
  parameter int NUM_W = 15,
  parameter int DIV_W = 4,
  parameter int CHK_W = NUM_W + DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_in,
  input  logic [NUM_W-1:0] num_in,
  input  logic [DIV_W-1:0] div_in,
  input  logic [NUM_W-1:0] est_in,
  output logic             v_q,
  output logic [NUM_W-1:0] quo_q,
  output logic [DIV_W-1:0] rem_q
);
  logic [CHK_W-1:0] next_mult;
  logic             bump;
  logic [NUM_W-1:0] quo;
  logic [CHK_W-1:0] rem_w;

  always_comb begin
    next_mult = CHK_W'(div_in) * (CHK_W'(est_in) + CHK_W'(1));
    bump      = (next_mult <= CHK_W'(num_in));
    quo       = est_in + NUM_W'(bump);
    rem_w     = CHK_W'(num_in) - CHK_W'(div_in) * CHK_W'(quo);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      quo_q <= '0;
      rem_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        quo_q <= quo;
        rem_q <= DIV_W'(rem_w);
      end
    end
  end
endmodule

// File: rtl/scdiv_top.sv
module scdiv_top #(
  parameter int NUM_W  = 15,
  parameter int SEL_W  = 2,
  parameter int DIV_W  = 4,
  parameter int SHIFT  = 17,
  parameter int PROD_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [NUM_W-1:0] in_num,
  input  logic [SEL_W-1:0] in_sel,
  output logic             out_valid,
  output logic [NUM_W-1:0] out_quo,
  output logic [DIV_W-1:0] out_rem
);
  localparam int K_W   = SHIFT + 1;
  localparam int CHK_W = NUM_W + DIV_W + 1;

  logic [DIV_W-1:0] rom_div;
  logic [K_W-1:0]   rom_k;
  logic             s1_v;
  logic [NUM_W-1:0] s1_num;
  logic [DIV_W-1:0] s1_div;
  logic [NUM_W-1:0] s1_est;

  scdiv_recip_rom #(
    .SEL_W(SEL_W), .DIV_W(DIV_W), .SHIFT(SHIFT), .K_W(K_W)
  ) u_rom (
    .sel(in_sel), .divisor(rom_div), .recip(rom_k)
  );

  scdiv_est_stage #(
    .NUM_W(NUM_W), .DIV_W(DIV_W), .SHIFT(SHIFT), .K_W(K_W), .PROD_W(PROD_W)
  ) u_est (
    .clk(clk), .rst(rst), .v_in(in_valid), .num_in(in_num),
    .div_in(rom_div), .k_in(rom_k),
    .v_q(s1_v), .num_q(s1_num), .div_q(s1_div), .est_q(s1_est)
  );

  scdiv_fix_stage #(
    .NUM_W(NUM_W), .DIV_W(DIV_W), .CHK_W(CHK_W)
  ) u_fix (
    .clk(clk), .rst(rst), .v_in(s1_v), .num_in(s1_num),
    .div_in(s1_div), .est_in(s1_est),
    .v_q(out_valid), .quo_q(out_quo), .rem_q(out_rem)
  );
endmodule

// File: rtl/scdiv_chk.sv
module scdiv_chk #(
  parameter int NUM_W = 15,
  parameter int SEL_W = 2,
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [NUM_W-1:0] in_num,
  input logic [SEL_W-1:0] in_sel,
  input logic             out_valid,
  input logic [NUM_W-1:0] out_quo,
  input logic [DIV_W-1:0] out_rem
);
  // R1 / R8: quotient and remainder rebuild the numerator
  assert_exact_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_quo) * scdiv_pkg::divisor_of(int'($past(in_sel, 2)))
                   + int'(out_rem)) == int'($past(in_num, 2)));

  assert_rem_below_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> int'(out_rem) < scdiv_pkg::divisor_of(int'($past(in_sel, 2))));

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  assert_reset_R4: assert property (@(posedge clk)
    rst |=> (!out_valid && out_quo == '0 && out_rem == '0));

  assert_bubble_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_quo) && $stable(out_rem)));
endmodule

bind scdiv_top scdiv_chk #(.NUM_W(NUM_W), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_num(in_num), .in_sel(in_sel),
  .out_valid(out_valid), .out_quo(out_quo), .out_rem(out_rem)
);

// File: tb/tb_scdiv_top.sv
`timescale 1ns/1ps
module tb_scdiv_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [14:0] in_num = '0;
  logic [1:0]  in_sel = '0;
  logic        out_valid;
  logic [14:0] out_quo;
  logic [3:0]  out_rem;

  int total = 0;
  int bad   = 0;

  // expectation history: h1 driven one step ago, h2 two steps ago
  logic        h1_v = 1'b0, h2_v = 1'b0;
  int          h1_q = 0, h1_r = 0, h2_q = 0, h2_r = 0;
  int          last_q = 0, last_r = 0;

  always #4 clk = ~clk;

  scdiv_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_num(in_num), .in_sel(in_sel),
    .out_valid(out_valid), .out_quo(out_quo), .out_rem(out_rem)
  );

  function automatic int bdiv(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 3;
      2'b10: return 6;
      default: return 10;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: check output for operand two steps back, then drive new one
  task automatic step(input logic v, input int m, input logic [1:0] s, input string tag);
    @(negedge clk);
    chk({tag, " R3 valid"}, int'(out_valid), int'(h2_v));
    if (h2_v) begin
      chk({tag, " R1 quotient"}, int'(out_quo), h2_q);
      chk({tag, " R2 remainder"}, int'(out_rem), h2_r);
      last_q = h2_q;
      last_r = h2_r;
    end else begin
      chk({tag, " R7 hold quotient"}, int'(out_quo), last_q);
      chk({tag, " R7 hold remainder"}, int'(out_rem), last_r);
    end
    h2_v = h1_v; h2_q = h1_q; h2_r = h1_r;
    h1_v = v;
    h1_q = v ? m / bdiv(s) : 0;
    h1_r = v ? m % bdiv(s) : 0;
    in_valid = v;
    in_num   = 15'(m);
    in_sel   = s;
  endtask

  task automatic drain(input string tag);
    step(1'b0, 0, 2'b00, tag);
    step(1'b0, 0, 2'b00, tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 reset valid", int'(out_valid), 0);
    chk("R4 reset quotient", int'(out_quo), 0);
    chk("R4 reset remainder", int'(out_rem), 0);
    rst = 1'b0;
    h1_v = 1'b0; h2_v = 1'b0; last_q = 0; last_r = 0;
  endtask

  task automatic t_reset_midstream();
    step(1'b1, 30000, 2'b11, "R4 mid");
    step(1'b1, 29999, 2'b10, "R4 mid");
    t_reset();
    drain("R4 after");
  endtask

  task automatic t_extremes();
    for (int s = 0; s < 4; s++) step(1'b1, 0, 2'(s), "R6 zero");
    for (int s = 0; s < 4; s++) step(1'b1, 32767, 2'(s), "R6 max");
    drain("R6");
  endtask

  task automatic t_short_estimate();
    step(1'b1, 3, 2'b01, "R8 3/3");
    step(1'b1, 6, 2'b10, "R8 6/6");
    step(1'b1, 10, 2'b11, "R8 10/10");
    step(1'b1, 32767, 2'b01, "R8 32767/3");
    step(1'b1, 30000, 2'b11, "R8 30000/10");
    drain("R8");
  endtask

  task automatic t_bubbles();
    step(1'b1, 1234, 2'b10, "R7 bubble");
    step(1'b0, 999, 2'b01, "R7 bubble");
    step(1'b0, 5, 2'b11, "R7 bubble");
    step(1'b1, 77, 2'b11, "R7 bubble");
    step(1'b0, 1, 2'b00, "R7 bubble");
    step(1'b1, 20001, 2'b01, "R7 bubble");
    drain("R7");
    drain("R7");
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 40; i++)
      step(1'b1, (i * 811 + 7) % 32768, 2'(i % 4), "R5 burst");
    drain("R5");
  endtask

  task automatic t_exhaustive();
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 32768; m++)
        step(1'b1, m, 2'(s), "R1 sweep");
    drain("R1 sweep");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_extremes();
    t_short_estimate();
    t_bubbles();
    t_back_to_back();
    t_reset_midstream();
    t_exhaustive();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule